// File: doc/BRIEF.md
# Indirect Redirection Register Access Port

This block is the software-facing register port of an interrupt routing controller. Only two registers sit on the bus. The first is an 8-bit select register. The second is a 32-bit data window. The window reads or writes whichever indirect register the select value names. That indirect space holds an identification register, a read-only version register, an arbitration alias of the identification register, and one 64-bit redirection entry per input pin. Each entry is reached as two 32-bit halves.

The block stores the entries and guards the fields that hardware owns: the remote-pending flag and the delivery-status flag. It also forces remote-pending low on any entry that is left in edge mode. It hands the per-pin mask and trigger state to the delivery engine, and it pulses a change strobe with the pin index whenever a write alters one of those two bits. Delivery itself is outside the block. The remote-pending flag is set and cleared by the delivery engine through per-pin inputs, and delivery status is supplied live by the engine.

Top module: `irq_route_regport`

## Requirements
- R1: Bus offset 0x00 holds an 8-bit select register that reads back in bits 7:0, with the upper bits reading as zero. Offset 0x10 is the window. Reads at any other offset return zero, and writes there change nothing.
- R2: Select 0x01 is the version register. It reads (pins − 1) in bits 23:16 and the version code 0x11 in bits 7:0, with all other bits zero. Writes to it are ignored.
- R3: Select 0x00 is the identification register, a 4-bit value held in bits 27:24 that software can write. Select 0x02 reads the same value, and writes through select 0x02 are ignored.
- R4: For a select of 0x10 or above, the entry index is (select − 0x10) >> 1. An odd select reaches bits 63:32 of the entry and an even select reaches bits 31:0. Selects 0x03 to 0x0F, and selects whose index is not below the pin count, read as all ones, and writes to them are discarded.
- R5: The writable entry fields are:
  - vector, bits 7:0
  - delivery mode, bits 10:8
  - destination mode, bit 11
  - polarity, bit 13
  - trigger, bit 15 (1 = level, 0 = edge)
  - mask, bit 16
  - destination, bits 63:56

  All other entry bits read as zero, except the two status bits covered by R6.
- R6: The delivery-status bit (bit 12) reads ds_i of that pin and is not writable. The remote-pending bit (bit 14) is set by rp_set_i and cleared by rp_clr_i; clear wins when both arrive together. A window write keeps remote-pending unchanged unless R7 applies.
- R7: Any write to an entry, to either half, that leaves the trigger bit at edge forces remote-pending to 0. This takes precedence over an rp_set_i in the same cycle.
- R8: Reset leaves every entry with only its mask bit set. It also clears the select register, the identification value and read data, and it holds the strobe low.
- R9: chg_stb_o pulses for one cycle, in the cycle after a low-half write that changes an entry's mask or trigger bit, with chg_idx_o naming that entry. No other write raises it.
- R10: rdata_o is loaded in the cycle after a read request and holds its value between reads. mask_o and level_o always show each entry's stored mask and trigger bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Read request at addr_i |
| wr_en_i | input | 1 | Write request at addr_i |
| addr_i | input | 8 | Bus offset (0x00 select, 0x10 window) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rp_set_i | input | NUM_PINS | Per-pin remote-pending set from the delivery engine |
| rp_clr_i | input | NUM_PINS | Per-pin remote-pending clear (end of interrupt) |
| ds_i | input | NUM_PINS | Per-pin live delivery status |
| mask_o | output | NUM_PINS | Stored mask bit of each entry |
| level_o | output | NUM_PINS | Stored trigger bit of each entry (1 = level) |
| chg_stb_o | output | 1 | One-cycle mask/trigger change strobe |
| chg_idx_o | output | $clog2(NUM_PINS) | Entry index carried with the strobe |

## Verification
The bench focuses on the places where an indirect decode goes wrong:
- **Select values around the table.** It tries the gap between the fixed registers and the table, the first index past the last pin, and the high half of the last pin. A decoder with the wrong offset or shift would hit a live entry there, or return data where all ones is expected.
- **Remote-pending collisions.** It drives the remote-pending bit against same-cycle window writes, sets and clears. A design that copied write data into the status bits, or let a set beat the edge-mode clear, would read back a stale pending flag.
- **Strobe conditions.** It writes values that change only the vector, that touch only the high half, and that toggle mask or trigger. A strobe keyed to any write rather than to a real change would then show extra pulses or a wrong index.

// File: rtl/irq_regport_pkg.sv
package irq_regport_pkg;
  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;

  localparam logic [7:0] SEL_ID  = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_ARB = 8'h02;
  localparam logic [7:0] SEL_TBL = 8'h10;

  localparam int F_DS   = 12;
  localparam int F_RP   = 14;
  localparam int F_TRIG = 15;
  localparam int F_MASK = 16;

  // software-writable entry bits: 63:56, 16, 15, 13, 11:0
  localparam logic [63:0] ENT_WR_MASK = 64'hFF00_0000_0001_AFFF;
  localparam logic [63:0] ENT_RST     = 64'h0000_0000_0001_0000;

  typedef enum logic [2:0] {
    K_ID,
    K_VER,
    K_ARB,
    K_ENT,
    K_BAD
  } kind_e;
endpackage

// File: rtl/irq_regport_decode.sv
module irq_regport_decode
  import irq_regport_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       sel_o,
  output kind_e            kind_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             hi_o
);
  logic [7:0] sel_q;
  logic [7:0] tbl_off;
  logic [6:0] ent_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          sel_q <= '0;
    else if (wr_en_i && addr_i == OFF_SEL) sel_q <= wdata_i;
  end

  always_comb begin
    tbl_off = sel_q - SEL_TBL;
    ent_n   = tbl_off[7:1];
    idx_o   = ent_n[IDX_W-1:0];
    hi_o    = tbl_off[0];
    if (sel_q == SEL_ID)                   kind_o = K_ID;
    else if (sel_q == SEL_VER)             kind_o = K_VER;
    else if (sel_q == SEL_ARB)             kind_o = K_ARB;
    else if (sel_q < SEL_TBL)              kind_o = K_BAD;
    else if (int'(ent_n) < NUM_PINS)       kind_o = K_ENT;
    else                                   kind_o = K_BAD;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/irq_regport_entry.sv
module irq_regport_entry
  import irq_regport_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_lo_i,
  input  logic        we_hi_i,
  input  logic [31:0] wdata_i,
  input  logic        rp_set_i,
  input  logic        rp_clr_i,
  output logic [63:0] ent_o,
  output logic        chg_o
);
  logic [63:0] ent_q, ent_d;
  logic        rp_d;

  always_comb begin
    ent_d = ent_q;
    if (we_lo_i) ent_d[31:0]  = wdata_i;
    if (we_hi_i) ent_d[63:32] = wdata_i;
    ent_d = ent_d & ENT_WR_MASK;
    rp_d  = (ent_q[F_RP] | rp_set_i) & ~rp_clr_i;
    // edge-mode write retires any pending level state
    if ((we_lo_i || we_hi_i) && !ent_d[F_TRIG]) rp_d = 1'b0;
    ent_d[F_RP] = rp_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ent_q <= ENT_RST;
    else         ent_q <= ent_d;
  end

  assign chg_o = we_lo_i && ((ent_d[F_MASK] != ent_q[F_MASK]) ||
                             (ent_d[F_TRIG] != ent_q[F_TRIG]));
  assign ent_o = ent_q;
endmodule

// File: rtl/irq_route_regport.sv
module irq_route_regport
  import irq_regport_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter logic [7:0] VER_CODE = 8'h11,
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_en_i,
  input  logic                wr_en_i,
  input  logic [7:0]          addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] rp_set_i,
  input  logic [NUM_PINS-1:0] rp_clr_i,
  input  logic [NUM_PINS-1:0] ds_i,
  output logic [NUM_PINS-1:0] mask_o,
  output logic [NUM_PINS-1:0] level_o,
  output logic                chg_stb_o,
  output logic [IDX_W-1:0]    chg_idx_o
);
  localparam logic [7:0] MAX_PIN = 8'(NUM_PINS - 1);

  logic [7:0]          sel_w;
  kind_e               kind_w;
  logic [IDX_W-1:0]    idx_w;
  logic                hi_w;
  logic                win_wr;
  logic [63:0]         ent_w [NUM_PINS];
  logic [NUM_PINS-1:0] chg_v;
  logic [NUM_PINS-1:0] rp_w;
  logic [3:0]          id_q;
  logic [31:0]         rd_mux, rdata_q;
  logic [63:0]         rd_ent;
  logic                chg_any, stb_q;
  logic [IDX_W-1:0]    chg_idx, idx_q;

  irq_regport_decode #(.NUM_PINS(NUM_PINS)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i[7:0]),
    .sel_o   (sel_w),
    .kind_o  (kind_w),
    .idx_o   (idx_w),
    .hi_o    (hi_w)
  );

  assign win_wr = wr_en_i && (addr_i == OFF_WIN);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
    logic hit;
    assign hit = win_wr && (kind_w == K_ENT) && (idx_w == IDX_W'(g));
    irq_regport_entry u_ent (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_lo_i  (hit && !hi_w),
      .we_hi_i  (hit && hi_w),
      .wdata_i  (wdata_i),
      .rp_set_i (rp_set_i[g]),
      .rp_clr_i (rp_clr_i[g]),
      .ent_o    (ent_w[g]),
      .chg_o    (chg_v[g])
    );
    assign mask_o[g]  = ent_w[g][F_MASK];
    assign level_o[g] = ent_w[g][F_TRIG];
    assign rp_w[g]    = ent_w[g][F_RP];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           id_q <= '0;
    else if (win_wr && kind_w == K_ID)     id_q <= wdata_i[27:24];
  end

  always_comb begin
    rd_ent        = ent_w[idx_w];
    rd_ent[F_DS]  = ds_i[idx_w];
    rd_mux        = '0;
    if (addr_i == OFF_SEL) begin
      rd_mux = {24'h0, sel_w};
    end else if (addr_i == OFF_WIN) begin
      unique case (kind_w)
        K_ID, K_ARB: rd_mux = {4'h0, id_q, 24'h0};
        K_VER:       rd_mux = {8'h0, MAX_PIN, 8'h0, VER_CODE};
        K_ENT:       rd_mux = hi_w ? rd_ent[63:32] : rd_ent[31:0];
        default:     rd_mux = '1;
      endcase
    end
  end

  always_comb begin
    chg_any = 1'b0;
    chg_idx = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (chg_v[i]) begin
        chg_any = 1'b1;
        chg_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      stb_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      if (rd_en_i) rdata_q <= rd_mux;
      stb_q <= chg_any;
      if (chg_any) idx_q <= chg_idx;
    end
  end

  assign rdata_o   = rdata_q;
  assign chg_stb_o = stb_q;
  assign chg_idx_o = idx_q;
endmodule

// File: rtl/irq_regport_chk.sv
module irq_regport_chk
  import irq_regport_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                rd_en_i,
  input logic                wr_en_i,
  input logic [7:0]          addr_i,
  input logic [31:0]         rdata_o,
  input logic [NUM_PINS-1:0] level_o,
  input logic                chg_stb_o,
  input logic [IDX_W-1:0]    chg_idx_o,
  input kind_e               kind_i,
  input logic [IDX_W-1:0]    idx_i,
  input logic [NUM_PINS-1:0] rp_i
);
  logic             lw_v;
  logic [IDX_W-1:0] lw_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lw_v   <= 1'b0;
      lw_idx <= '0;
    end else begin
      lw_v   <= wr_en_i && addr_i == OFF_WIN && kind_i == K_ENT;
      lw_idx <= idx_i;
    end
  end

  a_r1_other_offset_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i != OFF_SEL && addr_i != OFF_WIN |=> rdata_o == 32'h0);

  a_r2_version_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == OFF_WIN && kind_i == K_VER
    |=> rdata_o[23:16] == 8'(NUM_PINS - 1) && rdata_o[31:24] == 8'h0);

  a_r4_bad_select_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == OFF_WIN && kind_i == K_BAD |=> rdata_o == 32'hFFFF_FFFF);

  a_r7_edge_clears_rp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lw_v && !level_o[lw_idx] |-> !rp_i[lw_idx]);

  a_r9_strobe_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_stb_o |-> $past(wr_en_i && addr_i == OFF_WIN && kind_i == K_ENT));

  a_r9_strobe_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_stb_o |-> int'(chg_idx_o) < NUM_PINS);
endmodule

bind irq_route_regport irq_regport_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_en_i   (rd_en_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .level_o   (level_o),
  .chg_stb_o (chg_stb_o),
  .chg_idx_o (chg_idx_o),
  .kind_i    (kind_w),
  .idx_i     (idx_w),
  .rp_i      (rp_w)
);

// File: tb/tb_irq_route_regport.sv
`timescale 1ns/1ps
module tb_irq_route_regport;
  localparam int NP = 24;
  localparam int IW = $clog2(NP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] rp_set = '0, rp_clr = '0, ds = '0;
  logic [NP-1:0] mask_v, level_v;
  logic chg_stb;
  logic [IW-1:0] chg_idx;

  int errors = 0, checks = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #10 clk = ~clk;

  irq_route_regport #(.NUM_PINS(NP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .rp_set_i(rp_set), .rp_clr_i(rp_clr), .ds_i(ds),
    .mask_o(mask_v), .level_o(level_v),
    .chg_stb_o(chg_stb), .chg_idx_o(chg_idx)
  );

  // behavioural reference
  logic [63:0] m_ent [NP];
  logic [7:0]  m_sel;
  logic [3:0]  m_id;
  logic [31:0] m_rd;
  logic        m_stb;
  int          m_idx;
  string       m_tag = "R8", cur_tag = "R1";

  function automatic logic [31:0] mread();
    int k;
    logic [63:0] v;
    if (addr == 8'h00) return {24'h0, m_sel};
    if (addr != 8'h10) return 32'h0;
    if (m_sel == 8'h00 || m_sel == 8'h02) return {4'h0, m_id, 24'h0};
    if (m_sel == 8'h01) return {8'h0, 8'(NP - 1), 8'h0, 8'h11};
    if (m_sel < 8'h10) return 32'hFFFF_FFFF;
    k = (int'(m_sel) - 16) / 2;
    if (k >= NP) return 32'hFFFF_FFFF;
    v = m_ent[k];
    v[12] = ds[k];
    return m_sel[0] ? v[63:32] : v[31:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) m_ent[i] = 64'h1_0000;
      m_sel = 0; m_id = 0; m_rd = 0; m_stb = 0; m_idx = 0;
    end else begin
      if (rd_en) begin m_rd = mread(); m_tag = cur_tag; end
      m_stb = 0;
      for (int i = 0; i < NP; i++) begin
        if (rp_set[i]) m_ent[i][14] = 1'b1;
        if (rp_clr[i]) m_ent[i][14] = 1'b0;
      end
      if (wr_en && addr == 8'h00) m_sel = wdata[7:0];
      else if (wr_en && addr == 8'h10) begin
        if (m_sel == 8'h00) m_id = wdata[27:24];
        else if (m_sel >= 8'h10 && (int'(m_sel) - 16) / 2 < NP) begin
          int k;
          logic [63:0] o, n;
          k = (int'(m_sel) - 16) / 2;
          o = m_ent[k];
          n = o;
          if (m_sel[0]) n[63:32] = wdata; else n[31:0] = wdata;
          n[55:17] = '0;
          n[12] = 1'b0;
          n[14] = o[14];
          if (!n[15]) n[14] = 1'b0;
          if (!m_sel[0] && (n[16] != o[16] || n[15] != o[15])) begin
            m_stb = 1; m_idx = k;
          end
          m_ent[k] = n;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      logic [NP-1:0] em, el;
      for (int i = 0; i < NP; i++) begin em[i] = m_ent[i][16]; el[i] = m_ent[i][15]; end
      chk(rdata === m_rd, m_tag, 64'(rdata), 64'(m_rd));
      chk(chg_stb === m_stb, "R9", 64'(chg_stb), 64'(m_stb));
      if (m_stb) chk(int'(chg_idx) == m_idx, "R9", 64'(chg_idx), 64'(m_idx));
      chk(mask_v === em, "R10", 64'(mask_v), 64'(em));
      chk(level_v === el, "R10", 64'(level_v), 64'(el));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk); rd_en = 1; addr = a; cur_tag = tag;
    @(negedge clk); rd_en = 0; addr = 8'h00;
  endtask

  task automatic pulse_rp(input logic [NP-1:0] s, input logic [NP-1:0] c);
    @(negedge clk); rp_set = s; rp_clr = c;
    @(negedge clk); rp_set = '0; rp_clr = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(mask_v === '1, "R8", 64'(mask_v), 64'(NP'('1)));
    chk(rdata === 32'h0 && chg_stb === 1'b0, "R8", 64'(rdata), 64'h0);
    cmp_on = 1;

    rd(8'h00, "R8");                  // select cleared
    wr(8'h00, 32'h0000_0110); rd(8'h00, "R1");  // 8-bit select
    wr(8'h00, 8'h10); rd(8'h10, "R8");          // entry 0 masked
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, "R5");  // trigger flips -> strobe
    wr(8'h00, 8'h11); wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, "R5");
    wr(8'h00, 8'h10);
    pulse_rp(24'h1, 24'h0); rd(8'h10, "R6");
    wr(8'h10, 32'h0001_80AB); rd(8'h10, "R6");  // level write keeps pending
    ds = 24'h1; rd(8'h10, "R6"); ds = '0;
    wr(8'h10, 32'h0000_00AB); rd(8'h10, "R7");  // edge write clears, strobe
    wr(8'h10, 32'h0000_00CD); rd(8'h10, "R9");  // vector only, no strobe
    wr(8'h10, 32'h0000_80CD);
    pulse_rp(24'h1, 24'h1); rd(8'h10, "R6");    // clear wins
    pulse_rp(24'h1, 24'h0);
    @(negedge clk); wr_en = 1; addr = 8'h10; wdata = 32'h0000_0012; rp_set = 24'h1;
    @(negedge clk); wr_en = 0; rp_set = '0;
    rd(8'h10, "R7");

    wr(8'h00, 8'h01); rd(8'h10, "R2");
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, "R2");
    wr(8'h00, 8'h00); wr(8'h10, 32'hA5FF_FFFF); rd(8'h10, "R3");
    wr(8'h00, 8'h02); rd(8'h10, "R3");
    wr(8'h10, 32'h0300_0000); rd(8'h10, "R3");
    wr(8'h00, 8'h00); rd(8'h10, "R3");

    wr(8'h00, 8'h40); rd(8'h10, "R4");
    wr(8'h10, 32'h0000_0000); rd(8'h10, "R4");
    wr(8'h00, 8'h05); rd(8'h10, "R4");
    wr(8'h00, 8'h3F); wr(8'h10, 32'h5A00_0000); rd(8'h10, "R4");
    wr(8'h00, 8'h3E); wr(8'h10, 32'h0000_8077); rd(8'h10, "R4");
    wr(8'h00, 8'h2F); wr(8'h10, 32'h1234_5678); rd(8'h10, "R5");
    wr(8'h00, 8'h2E); rd(8'h10, "R5");

    wr(8'h20, 32'h0000_0033); rd(8'h20, "R1");
    rd(8'h00, "R1");
    rd(8'h04, "R1");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule